// File: doc/BRIEF.md
# Pointer Register Adjust Unit

This unit holds three 16-bit address pointers, named P, Q and S, and updates at most one of them on each clock edge. The pointer is picked by a select code and the update by an operation code. An update can add a signed 8-bit offset, add one after a byte transfer through the pointer, add two after a word transfer through the pointer, or load a full 16-bit value.

All arithmetic updates go through one shared adder. The adder's left operand is the selected pointer, and the result is written back into that same pointer. The three pointer values are always visible at the outputs.

The unit has no condition flags, so no update can change carry, zero or negative state held elsewhere. It is used next to an instruction sequencer. That sequencer fetches the offset byte in one cycle and issues the add in the following cycle.

Top module: `ptr_adjust_unit`

## Requirements
- R1: While `rst_n` is low, and directly after it goes low, all three pointers read 0x0000.
- R2: With `op`=3'b001, the pointer named by `sel` becomes its old value plus `imm`, and the outputs show this one clock edge after the request. `sel` encoding: 2'b00 is P, 2'b01 is Q, 2'b10 is S, 2'b11 is no pointer.
- R3: The 8-bit `imm` is treated as two's complement. Values 0x80 to 0xFF subtract 128 to 1, and 0x7F adds 127.
- R4: All results wrap modulo 65536. For example, 0xFFFF plus 1 gives 0x0000, and 0xFFFF plus 2 gives 0x0001.
- R5: With `op`=3'b010, the selected pointer increases by exactly 1.
- R6: With `op`=3'b011, the selected pointer increases by exactly 2.
- R7: With `op`=3'b100, the selected pointer takes the value of `ld_val`.
- R8: At most one pointer changes per edge. The two pointers that are not selected keep their values.
- R9: `op`=3'b000, the reserved codes 3'b101 to 3'b111, and `sel`=2'b11 leave all pointers unchanged, whatever `imm` and `ld_val` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel | input | 2 | Pointer select: 0 P, 1 Q, 2 S, 3 none |
| op | input | 3 | Update: 0 hold, 1 add signed imm, 2 plus one, 3 plus two, 4 load, 5-7 hold |
| imm | input | 8 | Signed offset for op 1 |
| ld_val | input | 16 | Value for op 4 |
| p_out | output | 16 | Pointer P |
| q_out | output | 16 | Pointer Q |
| s_out | output | 16 | Pointer S |

## Verification
The bench adds the most negative offset 0x80, the value 0xFB, and the most positive offset 0x7F. A design that zero-extends the offset would move S up by 128 instead of down. Each increment is also pushed across 0xFFFF. A design that keeps a seventeenth bit, or saturates, would show a wrong low word there. A load with `sel`=3 and a reserved op code carrying live data are both applied. A decoder that falls through to a default pointer would corrupt P in those cases.

// File: rtl/ptr_adjust_unit.sv
module ptr_adjust_unit #(
  parameter int PTR_W = 16,
  parameter int IMM_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       sel,
  input  logic [2:0]       op,
  input  logic [IMM_W-1:0] imm,
  input  logic [PTR_W-1:0] ld_val,
  output logic [PTR_W-1:0] p_out,
  output logic [PTR_W-1:0] q_out,
  output logic [PTR_W-1:0] s_out
);

  localparam logic [1:0] SEL_P = 2'd0, SEL_Q = 2'd1, SEL_S = 2'd2;
  localparam logic [2:0] OP_ADDI = 3'd1, OP_INC1 = 3'd2, OP_INC2 = 3'd3, OP_LOAD = 3'd4;

  logic [PTR_W-1:0] p_q, q_q, s_q;
  logic [PTR_W-1:0] cur, addend, nxt;
  logic             wr_en;

  assign cur = (sel == SEL_P) ? p_q : (sel == SEL_Q) ? q_q : s_q;

  always_comb begin
    case (op)
      OP_ADDI: addend = {{(PTR_W-IMM_W){imm[IMM_W-1]}}, imm};
      OP_INC1: addend = PTR_W'(1);
      OP_INC2: addend = PTR_W'(2);
      default: addend = '0;
    endcase
  end

  assign nxt   = (op == OP_LOAD) ? ld_val : cur + addend;
  assign wr_en = (sel != 2'd3) && (op >= OP_ADDI) && (op <= OP_LOAD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_q <= '0;
      q_q <= '0;
      s_q <= '0;
    end else if (wr_en) begin
      case (sel)
        SEL_P:   p_q <= nxt;
        SEL_Q:   q_q <= nxt;
        default: s_q <= nxt;
      endcase
    end
  end

  assign p_out = p_q;
  assign q_out = q_q;
  assign s_out = s_q;

  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |=> (p_out == '0 && q_out == '0 && s_out == '0));

  assert_one_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({p_out != $past(p_out), q_out != $past(q_out), s_out != $past(s_out)}) <= 1);

  assert_inc1_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_INC1 && sel == SEL_Q) |=> q_out == $past(q_out) + PTR_W'(1));

  assert_inc2_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_INC2 && sel == SEL_P) |=> p_out == $past(p_out) + PTR_W'(2));

  assert_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_LOAD && sel == SEL_S) |=> s_out == $past(ld_val));

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == 2'd3 || op == 3'd0 || op > OP_LOAD) |=> ($stable(p_out) && $stable(q_out) && $stable(s_out)));

endmodule

// File: tb/ptr_adjust_unit_test.sv
`timescale 1ns/1ps
module ptr_adjust_unit_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  sel = 2'd3;
  logic [2:0]  op = 3'd0;
  logic [7:0]  imm = '0;
  logic [15:0] ld_val = '0;
  logic [15:0] p_out, q_out, s_out;
  int applied = 0;
  int bad = 0;

  always #10 clk = ~clk;

  ptr_adjust_unit uut (.clk(clk), .rst_n(rst_n), .sel(sel), .op(op), .imm(imm),
                       .ld_val(ld_val), .p_out(p_out), .q_out(q_out), .s_out(s_out));

  // {req, sel, op, imm, ld_val, expected P, expected Q, expected S}
  localparam int NV = 15;
  localparam logic [80:0] VEC [NV] = '{
    {4'd7, 2'd0, 3'd4, 8'h00, 16'h1000, 16'h1000, 16'h0000, 16'h0000}, // R7
    {4'd2, 2'd0, 3'd1, 8'h05, 16'h0000, 16'h1005, 16'h0000, 16'h0000}, // R2
    {4'd3, 2'd0, 3'd1, 8'hFB, 16'h0000, 16'h1000, 16'h0000, 16'h0000}, // R3
    {4'd7, 2'd1, 3'd4, 8'h00, 16'hFFFF, 16'h1000, 16'hFFFF, 16'h0000}, // R7
    {4'd4, 2'd1, 3'd2, 8'h00, 16'h0000, 16'h1000, 16'h0000, 16'h0000}, // R4 wrap
    {4'd6, 2'd1, 3'd3, 8'h00, 16'h0000, 16'h1000, 16'h0002, 16'h0000}, // R6
    {4'd8, 2'd2, 3'd4, 8'h00, 16'h00FF, 16'h1000, 16'h0002, 16'h00FF}, // R8
    {4'd3, 2'd2, 3'd1, 8'h80, 16'h0000, 16'h1000, 16'h0002, 16'h007F}, // R3 min
    {4'd3, 2'd2, 3'd1, 8'h7F, 16'h0000, 16'h1000, 16'h0002, 16'h00FE}, // R3 max
    {4'd9, 2'd3, 3'd4, 8'h11, 16'h1234, 16'h1000, 16'h0002, 16'h00FE}, // R9 sel none
    {4'd9, 2'd0, 3'd5, 8'h22, 16'h5678, 16'h1000, 16'h0002, 16'h00FE}, // R9 reserved
    {4'd5, 2'd0, 3'd2, 8'h33, 16'h9999, 16'h1001, 16'h0002, 16'h00FE}, // R5
    {4'd7, 2'd2, 3'd4, 8'h00, 16'hFFFF, 16'h1001, 16'h0002, 16'hFFFF}, // R7
    {4'd4, 2'd2, 3'd3, 8'h00, 16'h0000, 16'h1001, 16'h0002, 16'h0001}, // R4 wrap by two
    {4'd9, 2'd0, 3'd0, 8'h44, 16'hABCD, 16'h1001, 16'h0002, 16'h0001}  // R9 hold
  };

  task automatic check(input int req, input logic [47:0] act, input logic [47:0] exp);
    applied++;
    if (act !== exp) begin
      bad++;
      $display("FAIL R%0d: got P=%h Q=%h S=%h, expected P=%h Q=%h S=%h",
               req, act[47:32], act[31:16], act[15:0], exp[47:32], exp[31:16], exp[15:0]);
    end
  endtask

  initial begin
    #(20 * 150000);
    bad++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    check(1, {p_out, q_out, s_out}, 48'h0); // R1 during reset
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      sel = VEC[i][76:75]; op = VEC[i][74:72]; imm = VEC[i][71:64]; ld_val = VEC[i][63:48];
      @(negedge clk);
      sel = 2'd3; op = 3'd0;
      check(int'(VEC[i][80:77]), {p_out, q_out, s_out}, VEC[i][47:0]);
    end
    // R1: asynchronous clear in the middle of the run
    #3 rst_n = 1'b0;
    #2 check(1, {p_out, q_out, s_out}, 48'h0);
    @(negedge clk);
    rst_n = 1'b1;
    // R2: positive add from zero on Q, and R8: P and S stay at zero
    sel = 2'd1; op = 3'd1; imm = 8'h7F;
    @(negedge clk);
    sel = 2'd3; op = 3'd0;
    check(2, {p_out, q_out, s_out}, {16'h0000, 16'h007F, 16'h0000});
    // R3, R4: negative offset from zero wraps to 0xFF80
    sel = 2'd0; op = 3'd1; imm = 8'h80;
    @(negedge clk);
    sel = 2'd3; op = 3'd0;
    check(3, {p_out, q_out, s_out}, {16'hFF80, 16'h007F, 16'h0000});
    $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
    $finish;
  end

endmodule